// File: doc/BRIEF.md
# 64-bit Virtual Address Segment Translator

This block turns a 64-bit virtual address into a physical address for an instruction fetch, a data load or a data store. The region of the address space is decoded from the top address bits. Unmapped windows pass straight through with their upper bits cleared. Every region that would need a page-table lookup raises an address error instead, because the block has no lookup structure.

A requester presents the virtual address, the access kind and the access size, with `req_valid` high. Exactly one clock later the block returns either a translated physical address or an address-error flag. The error flag comes with a one-bit code that tells a store-type fault from a load-type fault. The requester should use this block ahead of a memory port and route faults to its exception logic.

The alignment check comes first. An access that is not aligned to its own size faults even when it targets an unmapped window.

Top module: `va_seg_xlate`

## Requirements
- R1: A response (`rsp_valid` high) appears on the clock edge after each cycle where `req_valid` is high, and only then. The synchronous active-high `rst` clears `rsp_valid`, and while `rsp_valid` is low, `rsp_ok` and `rsp_exc` are low.
- R2: When bits 63:62 are 2'b10 (direct physical window) and the access is aligned, the response is a success with `rsp_paddr` equal to bits 58:0 of the address, zero-extended. Bits 61:59 do not change the result.
- R3: When bits 63:62 are 2'b11, bits 61:31 are all ones, bits 30:29 are 2'b00 or 2'b01, and the access is aligned, the response is a success with `rsp_paddr` equal to bits 28:0, zero-extended.
- R4: When bits 63:62 are 2'b11, bits 61:31 are all ones and bits 30:29 are 2'b10 or 2'b11, the response is an address error.
- R5: When bits 63:62 are 2'b11 and bits 61:31 are not all ones, the response is an address error.
- R6: When bits 63:62 are 2'b00 or 2'b01, the response is an address error.
- R7: The access kind is encoded as 2'b00 fetch, 2'b01 load, 2'b10 store, and 2'b11 is treated as a load. `rsp_exc_store` is high on an error exactly when the kind was 2'b10 (store), and it is low for the other kinds.
- R8: The access size is encoded as 2'b00 = 1 byte, 2'b01 = 2, 2'b10 = 4 and 2'b11 = 8 bytes. An address that is not a multiple of the size gives an address error in every region, with the code chosen as in R7.
- R9: On every response exactly one of `rsp_ok` and `rsp_exc` is high. Whenever `rsp_exc` is high, `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| req_size | input | 2 | Access size: 00=1, 01=2, 10=4, 11=8 bytes |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | 64 | Physical address, zero on error |
| rsp_exc | output | 1 | Address error raised |
| rsp_exc_store | output | 1 | Error code: 1 store-type, 0 load-type |

## Verification
The assertions assume that `req_kind` and `req_size` are known values in every cycle where `req_valid` is high. They also assume that the request fields are sampled only in that cycle, so a response depends only on the request one clock earlier. The stimulus always drives defined values and changes the inputs only at the falling clock edge. It steers random addresses into each region, including the narrow kernel compatibility windows that plain random values would almost never hit. It clears the low address bits on part of the requests, so that aligned and misaligned accesses both occur in every region.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;

    localparam int VA_W      = 64;
    localparam int REGION_LO = 62;   // bits 63:62 select the region
    localparam int DIRECT_W  = 59;   // direct window keeps bits 58:0
    localparam int COMPAT_W  = 29;   // compatibility windows keep bits 28:0
    localparam int COMPAT_LO = 31;   // bits 61:31 must be all ones for compat
    localparam int ALIGN_W   = 3;    // largest access is 8 bytes

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_B1 = 2'b00,
        SZ_B2 = 2'b01,
        SZ_B4 = 2'b10,
        SZ_B8 = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        RGN_USER   = 2'b00,
        RGN_SUPER  = 2'b01,
        RGN_DIRECT = 2'b10,
        RGN_KERNEL = 2'b11
    } region_e;

    typedef struct packed {
        logic            ok;
        logic            exc;
        logic            exc_store;
        logic [VA_W-1:0] paddr;
    } xlate_rsp_t;

    // Low-bit mask that must be clear for an access of the given size.
    function automatic logic [ALIGN_W-1:0] align_mask(input acc_size_e sz);
        case (sz)
            SZ_B1:   return 3'b000;
            SZ_B2:   return 3'b001;
            SZ_B4:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    // Only a data store gets the store-type code; reserved kind acts as load.
    function automatic logic kind_is_store(input acc_kind_e k);
        return (k == ACC_STORE);
    endfunction

endpackage

// File: rtl/va_align_chk.sv
module va_align_chk
    import va_xlate_pkg::*;
(
    input  logic [ALIGN_W-1:0] low_bits,
    input  acc_size_e          size,
    output logic               misaligned
);
    logic [ALIGN_W-1:0] mask;

    always_comb begin
        mask       = align_mask(size);
        misaligned = |(low_bits & mask);
    end
endmodule

// File: rtl/va_seg_decode.sv
module va_seg_decode
    import va_xlate_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    output logic            pass,
    output logic [VA_W-1:0] paddr
);
    localparam int COMPAT_ONES = REGION_LO - COMPAT_LO;   // width of bits 61:31

    region_e    region;
    logic       compat_hit;
    logic [1:0] compat_sel;

    always_comb begin
        region     = region_e'(vaddr[VA_W-1:REGION_LO]);
        compat_hit = &vaddr[REGION_LO-1:COMPAT_LO];
        compat_sel = vaddr[COMPAT_LO-1:COMPAT_W];
        pass       = 1'b0;
        paddr      = '0;
        case (region)
            RGN_DIRECT: begin
                pass  = 1'b1;
                paddr = {{(VA_W-DIRECT_W){1'b0}}, vaddr[DIRECT_W-1:0]};
            end
            RGN_KERNEL: begin
                // only the two unmapped compatibility windows translate
                if (compat_hit && !compat_sel[1]) begin
                    pass  = 1'b1;
                    paddr = {{(VA_W-COMPAT_W){1'b0}}, vaddr[COMPAT_W-1:0]};
                end
            end
            default: begin
                pass = 1'b0;
            end
        endcase
    end

    logic unused_w;
    assign unused_w = (COMPAT_ONES == 0);
endmodule

// File: rtl/va_seg_xlate.sv
module va_seg_xlate
    import va_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [63:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  req_size,
    output logic        rsp_valid,
    output logic        rsp_ok,
    output logic [63:0] rsp_paddr,
    output logic        rsp_exc,
    output logic        rsp_exc_store
);
    logic            misaligned;
    logic            seg_pass;
    logic [VA_W-1:0] seg_paddr;
    xlate_rsp_t      nxt;
    xlate_rsp_t      cur;
    logic            vld_q;

    va_align_chk u_align (
        .low_bits   (req_vaddr[ALIGN_W-1:0]),
        .size       (acc_size_e'(req_size)),
        .misaligned (misaligned)
    );

    va_seg_decode u_decode (
        .vaddr (req_vaddr),
        .pass  (seg_pass),
        .paddr (seg_paddr)
    );

    always_comb begin
        nxt           = '0;
        nxt.ok        = seg_pass && !misaligned;
        nxt.exc       = !nxt.ok;
        nxt.exc_store = nxt.exc && kind_is_store(acc_kind_e'(req_kind));
        nxt.paddr     = nxt.ok ? seg_paddr : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur   <= '0;
        end else begin
            vld_q <= req_valid;
            cur   <= req_valid ? nxt : '0;
        end
    end

    assign rsp_valid     = vld_q;
    assign rsp_ok        = cur.ok;
    assign rsp_exc       = cur.exc;
    assign rsp_exc_store = cur.exc_store;
    assign rsp_paddr     = cur.paddr;
endmodule

// File: rtl/va_seg_xlate_chk.sv
module va_seg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [63:0] req_vaddr,
    input logic [1:0]  req_kind,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic        rsp_ok,
    input logic [63:0] rsp_paddr,
    input logic        rsp_exc,
    input logic        rsp_exc_store
);
    logic       req_aligned;
    logic [2:0] need_zero;

    always_comb begin
        need_zero   = (req_size == 2'd0) ? 3'd0 :
                      (req_size == 2'd1) ? 3'd1 :
                      (req_size == 2'd2) ? 3'd3 : 3'd7;
        req_aligned = (req_vaddr[2:0] & need_zero) == 3'd0;
    end

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r1_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_ok && !rsp_exc));

    a_r2_direct_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vaddr[63:62] == 2'b10 && req_aligned)
        |=> (rsp_ok && rsp_paddr == {5'd0, $past(req_vaddr[58:0])}));

    a_r3_compat_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vaddr[63:62] == 2'b11 && (&req_vaddr[61:31])
         && !req_vaddr[30] && req_aligned)
        |=> (rsp_ok && rsp_paddr == {35'd0, $past(req_vaddr[28:0])}));

    a_r4_mapped_compat_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vaddr[63:62] == 2'b11 && (&req_vaddr[61:31]) && req_vaddr[30])
        |=> rsp_exc);

    a_r5_ext_kernel_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_vaddr[63:62] == 2'b11 && !(&req_vaddr[61:31]))
        |=> rsp_exc);

    a_r6_user_super_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_vaddr[63]) |=> rsp_exc);

    a_r7_store_code: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b10) |=> (rsp_exc == rsp_exc_store));

    a_r7_load_code: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 2'b10) |=> !rsp_exc_store);

    a_r8_misaligned_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_aligned) |=> rsp_exc);

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_ok, rsp_exc}) == 1));

    a_r9_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
        rsp_exc |-> (rsp_paddr == 64'd0));
endmodule

bind va_seg_xlate va_seg_xlate_chk u_chk (.*);

// File: tb/va_seg_xlate_bench.sv
`timescale 1ns/1ps
module va_seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic [1:0]  req_kind;
    logic [1:0]  req_size;
    logic        rsp_valid, rsp_ok, rsp_exc, rsp_exc_store;
    logic [63:0] rsp_paddr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    va_seg_xlate u_va_seg_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_size(req_size), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc),
        .rsp_exc_store(rsp_exc_store)
    );

    // Reference outcome written from the requirements.
    function automatic void model(input logic [63:0] va, input logic [1:0] kind,
                                  input logic [1:0] sz, output logic ok,
                                  output logic st, output logic [63:0] pa);
        logic [63:0] bytes;
        logic        xl;
        bytes = 64'd1 << sz;                          // R8 size encoding
        xl    = 1'b0;
        pa    = 64'd0;
        if (va[63:62] == 2'b10) begin                 // R2
            xl = 1'b1; pa = {5'd0, va[58:0]};
        end else if (va[63:62] == 2'b11 && va[61:31] == {31{1'b1}}
                     && va[30:29] inside {2'b00, 2'b01}) begin   // R3
            xl = 1'b1; pa = {35'd0, va[28:0]};
        end                                           // R4 R5 R6 fault
        ok = xl && ((va % bytes) == 64'd0);
        if (!ok) pa = 64'd0;                          // R9
        st = !ok && (kind == 2'b10);                  // R7
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xact(input string req, input logic [63:0] va,
                        input logic [1:0] kind, input logic [1:0] sz);
        logic eok, est;
        logic [63:0] epa;
        model(va, kind, sz, eok, est, epa);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R1 valid"}, {63'd0, rsp_valid}, 64'd1);
        check({req, " R9 ok/exc"}, {62'd0, rsp_ok, rsp_exc}, {62'd0, eok, !eok});
        check({req, " paddr"}, rsp_paddr, epa);
        check({req, " R7 code"}, {63'd0, rsp_exc_store}, {63'd0, est});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] va;
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_size = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 reset ok/exc", {62'd0, rsp_ok, rsp_exc}, 64'd0);
        rst = 1'b0;

        // R2 direct window, cache bits varied
        xact("R2 direct", 64'h8000_0000_1234_5678, 2'b01, 2'b11);
        xact("R2 cache bits", 64'hB800_0000_1234_5678, 2'b00, 2'b10);
        xact("R2 top phys", 64'hBFFF_FFFF_FFFF_FFF8, 2'b10, 2'b11);
        // R3 compat windows
        xact("R3 cached", 64'hFFFF_FFFF_8000_1000, 2'b00, 2'b10);
        xact("R3 uncached", 64'hFFFF_FFFF_BFFF_FFFE, 2'b10, 2'b01);
        // R4 mapped compat windows
        xact("R4 sseg", 64'hFFFF_FFFF_C000_0000, 2'b10, 2'b00);
        xact("R4 kseg3", 64'hFFFF_FFFF_E000_0000, 2'b01, 2'b00);
        // R5 extended kernel
        xact("R5 xkseg", 64'hC000_0000_0000_0000, 2'b10, 2'b00);
        xact("R5 near compat", 64'hFFFF_FFFF_7FFF_FFF0, 2'b00, 2'b11);
        // R6 user and supervisor
        xact("R6 user", 64'h0000_0000_0040_0000, 2'b10, 2'b10);
        xact("R6 super", 64'h4000_0000_0000_0000, 2'b00, 2'b00);
        // R7 reserved kind acts as load
        xact("R7 kind11", 64'h0000_0000_0000_0000, 2'b11, 2'b00);
        // R8 misaligned in unmapped windows
        xact("R8 mis store", 64'h8000_0000_0000_0004, 2'b10, 2'b11);
        xact("R8 mis load", 64'hFFFF_FFFF_8000_0001, 2'b01, 2'b01);
        xact("R8 byte any", 64'h8000_0000_0000_0007, 2'b01, 2'b00);

        // R1 idle: no request, no response
        @(negedge clk);
        check("R1 idle", {61'd0, rsp_valid, rsp_ok, rsp_exc}, 64'd0);

        for (int i = 0; i < 400; i++) begin
            va = {$urandom, $urandom};
            case ($urandom % 5)
                0: va[63:62] = 2'b10;
                1: begin va[63:62] = 2'b11; va[61:31] = '1; end
                2: va[63:62] = 2'b11;
                default: ;
            endcase
            if ($urandom % 2) va[2:0] = 3'b000;
            xact("R2-9 random", va, 2'($urandom), 2'($urandom));
        end

        // back-to-back requests, then reset mid-stream (R1)
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 64'h8000_0000_0000_0010; req_kind = 2'b01; req_size = 2'b11;
        @(negedge clk);
        req_vaddr = 64'h0;
        check("R1 b2b first", {62'd0, rsp_valid, rsp_ok}, 64'd3);
        @(negedge clk);
        check("R1 b2b second", {61'd0, rsp_valid, rsp_ok, rsp_exc}, 64'd5);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", {63'd0, rsp_valid}, 64'd0);
        rst = 1'b0; req_valid = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule